// File: doc/BRIEF.md
# Dual-Format Serial Audio Receiver

This block turns a three-wire stereo audio stream into parallel samples. The three wires are a bit clock, a word clock and a data line. The bit clock is the block's own clock. The word clock and the data line are sampled on its rising edge. A static format input picks one of two framings:

- **Left-justified:** each word's most significant bit sits in the first bit slot of the half-frame.
- **I2S-style:** the most significant bit is delayed by one slot.

Each channel word is 24 bits of two's-complement audio, sent MSB first. Any slots after the 24th data bit of a half-frame are padding and are dropped.

Once per frame, after the right-channel word is complete, the block updates its left and right output registers together and pulses a one-cycle strobe. A downstream stage picks up the pair in the bit-clock domain. Frames of 48 and 64 bit slots are both handled. This includes the I2S case at 48 slots, where the right word's last bit arrives in the first slot of the next half-frame.

Top module: `audrx_serial_rx`

## Requirements
- R1: Data is sampled on the rising clock edge, MSB first. The first data bit of a word lands in output bit 23, and the value is presented unchanged as a 24-bit two's-complement number (0x800000 and 0x7FFFFF pass through intact).
- R2: With `fmt_sel` = 0 (left-justified), the MSB is the bit sampled on the first rising edge at which a new word-clock level is seen. Word clock = 1 marks the left channel.
- R3: With `fmt_sel` = 1 (I2S-style), the MSB is the bit sampled one rising edge after the first edge showing the new word-clock level. Word clock = 0 marks the left channel.
- R4: Slots after the 24th data bit of a half-frame have no effect on either output word, whatever their values.
- R5: Frames of 64 bit slots (32 per half) are received correctly in both formats.
- R6: Frames of 48 bit slots (24 per half) are received correctly in both formats. In I2S-style mode the LSB is taken from the first slot of the following half-frame, and it is credited to the earlier word.
- R7: `valid_o` is high for exactly one cycle: the cycle after the rising edge that samples the right word's LSB. In that cycle `left_o` and `right_o` change together. At all other times they hold. Each frame gives exactly one strobe.
- R8: A synchronous active-high `rst` clears `left_o`, `right_o` and `valid_o` to zero. The first word-clock level sampled after reset is taken as a reference and not as a transition, so no word is captured until the word clock next changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fmt_sel | input | 1 | Framing select: 0 left-justified, 1 I2S-style; change only under reset |
| wclk | input | 1 | Word clock marking the channel of each half-frame |
| sdata | input | 1 | Serial audio data, MSB first |
| left_o | output | 24 | Last complete left-channel sample |
| right_o | output | 24 | Last complete right-channel sample |
| valid_o | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
The only timed result is the pair strobe. It is due in the cycle after the rising edge that samples the right word's LSB, and both sample outputs are due in that same cycle. For the I2S-style 48-slot case, that edge is the first slot of the next half-frame.

The driver changes inputs on falling edges. It keeps a count of rising edges, and when it drives a right-word LSB it queues the count at which the strobe must be seen. The monitor checks on falling edges, compares the strobe's cycle against that queue, and compares the pair against the words queued when the frame was sent. A strobe with nothing queued, or a queued frame that never arrives, is reported as a failure.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int SLOT_W   = 6;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        FMT_LEFT_JUST = 1'b0,
        FMT_I2S       = 1'b1
    } fmt_e;

    typedef struct packed {
        logic    done;
        logic    is_left;
        sample_t word;
    } word_evt_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    // Channel decode: left is word clock high in left-justified, low in I2S-style.
    function automatic logic lvl_is_left(input logic lvl, input fmt_e f);
        return lvl ^ (f == FMT_I2S);
    endfunction

endpackage

// File: rtl/audrx_slot_track.sv
module audrx_slot_track
    import audrx_pkg::*;
#(
    parameter int SLOT_BITS = SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wclk,
    output logic                 edge_o,
    output logic [SLOT_BITS-1:0] slot_now_o,
    output logic [SLOT_BITS-1:0] slot_prev_o,
    output logic                 lvl_prev_o
);

    localparam logic [SLOT_BITS-1:0] SLOT_MAX = {SLOT_BITS{1'b1}};

    logic                 primed_q;
    logic                 wclk_q;
    logic [SLOT_BITS-1:0] slot_q;

    assign edge_o = primed_q && (wclk != wclk_q);

    always_comb begin
        if (edge_o) begin
            slot_now_o = '0;
        end else if (slot_q == SLOT_MAX) begin
            slot_now_o = slot_q;
        end else begin
            slot_now_o = slot_q + 1'b1;
        end
    end

    assign slot_prev_o = slot_q;
    assign lvl_prev_o  = wclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            primed_q <= 1'b0;
            wclk_q   <= 1'b0;
            slot_q   <= SLOT_MAX;
        end else begin
            primed_q <= 1'b1;
            wclk_q   <= wclk;
            slot_q   <= slot_now_o;
        end
    end

    // R8: the first sample after reset primes the tracker and counts no slot
    first_sample_chk: assert property (@(posedge clk) rst |=> (slot_q == SLOT_MAX));

    // R2
    edge_restart_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o |=> (slot_q == '0));

endmodule

// File: rtl/audrx_word_shift.sv
module audrx_word_shift
    import audrx_pkg::*;
#(
    parameter int WORD_W    = SAMPLE_W,
    parameter int SLOT_BITS = SLOT_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  fmt_e                 fmt,
    input  logic                 sdata,
    input  logic                 wclk,
    input  logic                 lvl_prev,
    input  logic                 edge_i,
    input  logic [SLOT_BITS-1:0] slot_now,
    input  logic [SLOT_BITS-1:0] slot_prev,
    output word_evt_t            evt_o
);

    localparam logic [SLOT_BITS-1:0] LJ_LAST   = SLOT_BITS'(WORD_W - 1);
    localparam logic [SLOT_BITS-1:0] I2S_FIRST = SLOT_BITS'(1);
    localparam logic [SLOT_BITS-1:0] I2S_LAST  = SLOT_BITS'(WORD_W);

    logic [WORD_W-1:0] shift_q;
    logic [WORD_W-1:0] shift_d;
    logic              cap;
    logic              done;
    logic              lvl;
    logic              wrap;

    assign shift_d = {shift_q[WORD_W-2:0], sdata};
    assign wrap    = (fmt == FMT_I2S) && edge_i && (slot_prev == LJ_LAST);

    always_comb begin
        lvl = wclk;
        if (wrap) begin
            cap  = 1'b1;
            done = 1'b1;
            lvl  = lvl_prev;
        end else if (fmt == FMT_I2S) begin
            cap  = (slot_now >= I2S_FIRST) && (slot_now <= I2S_LAST);
            done = (slot_now == I2S_LAST);
        end else begin
            cap  = (slot_now <= LJ_LAST);
            done = (slot_now == LJ_LAST);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
        end else if (cap) begin
            shift_q <= shift_d;
        end
    end

    assign evt_o.done    = done && !rst;
    assign evt_o.is_left = lvl_is_left(lvl, fmt);
    assign evt_o.word    = shift_d;

    // R4: at most one completed word per half-frame
    word_gap_chk: assert property (@(posedge clk) disable iff (rst)
        evt_o.done |=> !evt_o.done);

endmodule

// File: rtl/audrx_pair_latch.sv
module audrx_pair_latch
    import audrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt_i,
    output pair_t     pair_o,
    output logic      valid_o
);

    sample_t left_hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_hold_q <= '0;
            pair_o      <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (evt_i.done && evt_i.is_left) begin
                left_hold_q <= evt_i.word;
            end
            if (evt_i.done && !evt_i.is_left) begin
                pair_o.left  <= left_hold_q;
                pair_o.right <= evt_i.word;
                valid_o      <= 1'b1;
            end
        end
    end

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R7
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(pair_o.left) || !$stable(pair_o.right)) |-> valid_o);

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && pair_o.left == '0 && pair_o.right == '0));

endmodule

// File: rtl/audrx_serial_rx.sv
module audrx_serial_rx
    import audrx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                fmt_sel,
    input  logic                wclk,
    input  logic                sdata,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);

    fmt_e              fmt;
    logic              edge_w;
    logic [SLOT_W-1:0] slot_now;
    logic [SLOT_W-1:0] slot_prev;
    logic              lvl_prev;
    word_evt_t         evt;
    pair_t             pair;

    assign fmt = fmt_e'(fmt_sel);

    audrx_slot_track #(.SLOT_BITS(SLOT_W)) u_track (
        .clk        (clk),
        .rst        (rst),
        .wclk       (wclk),
        .edge_o     (edge_w),
        .slot_now_o (slot_now),
        .slot_prev_o(slot_prev),
        .lvl_prev_o (lvl_prev)
    );

    audrx_word_shift #(.WORD_W(SAMPLE_W), .SLOT_BITS(SLOT_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .fmt      (fmt),
        .sdata    (sdata),
        .wclk     (wclk),
        .lvl_prev (lvl_prev),
        .edge_i   (edge_w),
        .slot_now (slot_now),
        .slot_prev(slot_prev),
        .evt_o    (evt)
    );

    audrx_pair_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .pair_o (pair),
        .valid_o(valid_o)
    );

    assign left_o  = pair.left;
    assign right_o = pair.right;

endmodule

// File: tb/audrx_serial_rx_test.sv
module audrx_serial_rx_test;

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fmt_sel = 1'b0;
    logic        wclk = 1'b0;
    logic        sdata = 1'b0;
    logic [23:0] left_o;
    logic [23:0] right_o;
    logic        valid_o;

    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    bit   done_flag = 1'b0;
    logic carry = 1'b0;
    bit   carry_right = 1'b0;
    exp_t exp_q[$];
    int   due_q[$];

    audrx_serial_rx uut (
        .clk    (clk),
        .rst    (rst),
        .fmt_sel(fmt_sel),
        .wclk   (wclk),
        .sdata  (sdata),
        .left_o (left_o),
        .right_o(right_o),
        .valid_o(valid_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && valid_o) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R8 unexpected strobe", {left_o, right_o}, '0);
            end else begin
                exp_t e;
                int   d;
                e = exp_q.pop_front();
                d = (due_q.size() != 0) ? due_q.pop_front() : -1;
                check(cyc == d, {"R7 strobe cycle ", e.tag}, 48'(cyc), 48'(d));
                check(left_o == e.l, {"left ", e.tag}, 48'(left_o), 48'(e.l));
                check(right_o == e.r, {"right ", e.tag}, 48'(right_o), 48'(e.r));
            end
        end
    end

    task automatic drive_half(input logic lvl, input logic [23:0] w, input int hlen, input bit is_right);
        for (int s = 0; s < hlen; s++) begin
            logic b;
            bit   lsb;
            b   = 1'($urandom & 1);   // padding slots carry noise (R4)
            lsb = 1'b0;
            if (!fmt_sel) begin
                if (s < 24) b = w[23-s];
                lsb = (s == 23) && is_right;
            end else begin
                if (s == 0) begin
                    b   = carry;
                    lsb = carry_right;
                end else if (s <= 24) begin
                    b   = w[24-s];
                    lsb = (s == 24) && is_right;
                end
            end
            @(negedge clk);
            wclk  = lvl;
            sdata = b;
            if (lsb) due_q.push_back(cyc + 1);
        end
        carry       = (hlen == 24) ? w[0] : 1'($urandom & 1);
        carry_right = fmt_sel && (hlen == 24) && is_right;
    endtask

    task automatic send_frame(input logic [23:0] l, input logic [23:0] r, input int hlen, input string tag);
        logic left_lvl;
        exp_t e;
        left_lvl = ~fmt_sel;
        e.l = l;
        e.r = r;
        e.tag = tag;
        exp_q.push_back(e);
        drive_half(left_lvl, l, hlen, 1'b0);
        drive_half(~left_lvl, r, hlen, 1'b1);
    endtask

    task automatic start_section(input logic f);
        @(negedge clk);
        rst         = 1'b1;
        fmt_sel     = f;
        wclk        = f;        // idle at the right-channel level
        carry       = 1'b0;
        carry_right = 1'b0;
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R8 reset state",
              {left_o, right_o}, '0);
        rst = 1'b0;
        repeat (40) @(negedge clk);   // R8: idle level is a reference, no word from it
        check(exp_q.size() == 0 && left_o == '0, "R8 no capture before first change",
              48'(left_o), '0);
    endtask

    task automatic end_section(input int hlen);
        drive_half(~fmt_sel, 24'h0, hlen, 1'b0);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R7 one strobe per frame", 48'(exp_q.size()), '0);
    endtask

    initial begin
        start_section(1'b0);
        send_frame(24'h123456, 24'hFEDCBA, 32, "R2 R5 R1");
        send_frame(24'h7FFFFF, 24'h800000, 32, "R1 R2 R5 extremes");
        send_frame(24'h000001, 24'hFFFFFF, 32, "R4 padding R5");
        end_section(32);

        start_section(1'b0);
        send_frame(24'hA5A5A5, 24'h5A5A5A, 24, "R2 R6");
        send_frame(24'h800001, 24'h7FFFFE, 24, "R1 R6");
        end_section(24);

        start_section(1'b1);
        send_frame(24'h13579B, 24'h2468AC, 32, "R3 R5");
        send_frame(24'h800000, 24'h7FFFFF, 32, "R3 R4 extremes");
        end_section(32);

        start_section(1'b1);
        send_frame(24'hC0FFEE, 24'h0BEEF1, 24, "R3 R6 wrap");
        send_frame(24'h000001, 24'hFFFFFF, 24, "R6 LSB carry");
        end_section(24);

        for (int k = 0; k < 4; k++) begin
            start_section(1'(k & 1));
            for (int n = 0; n < 5; n++) begin
                send_frame(24'($urandom), 24'($urandom), (k < 2) ? 32 : 24, "R1 R4 random");
            end
            end_section((k < 2) ? 32 : 24);
        end

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done_flag) begin
            done_flag = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule